// File: doc/BRIEF.md
# Wrap-Around Product-Term Sharing Array

This block is the OR steering network that sits between the AND array and the macrocells of one logic block. Its input is a flat vector of product terms, grouped into consecutive clusters of five terms. Each cluster is first reduced to a single cluster OR. A static configuration then hands that cluster OR to one nearby sharing output. Each output sums every cluster steered to it, so one function can draw on up to seven clusters, or 35 terms.

Output i may draw on clusters i through i+6, taken modulo the cluster count. Because of this wrap, the top outputs can use the lowest clusters. Each cluster has an enable bit and a 3-bit offset k, which sends it to output (c - k) mod 32. Offset 7 is not a legal window position. A cluster with that offset is dropped and a configuration-error flag is raised.

For functions of five terms or fewer, a separate bypass output per macrocell always carries the OR of that macrocell's own cluster, whatever the configuration says. The block is purely combinational and has no storage, so it has no states or transitions. Its outputs follow its inputs in the same time step.

Top module: `ptsa_share_array`

## Requirements
- R1: `byp_out[i]` equals the OR of `pt_in[5i+4:5i]` for every i, whatever the values of `clu_en` and `clu_off`.
- R2: A cluster c with `clu_en[c]`=1 and offset `clu_off[3c+2:3c]`=k, where k is 0 to 6, drives only `sum_out[(c-k) mod 32]`, and adds no 1 to any other output.
- R3: Steering wraps around. For example, cluster 0 with offset 1 feeds output 31, and cluster 5 with offset 6 feeds output 31.
- R4: `sum_out[i]` is the OR of the cluster ORs of all clusters steered to output i. It is 0 when no enabled cluster is steered there, or when all steered clusters have all terms at 0.
- R5: A cluster with `clu_en[c]`=0 adds nothing to any `sum_out` bit, whatever its offset. With `clu_en` all zero, `sum_out` is all zero.
- R6: An enabled cluster with offset 7 adds nothing to any `sum_out` bit and sets `cfg_bad` to 1. `cfg_bad` is 0 when no enabled cluster has offset 7. A disabled cluster with offset 7 does not set `cfg_bad`.
- R7: A single output collects up to 35 terms, from seven clusters at offsets 0 through 6. Any one of those 35 terms set alone drives that output to 1.
- R8: The outputs are a pure function of the present inputs, with no clock or stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pt_in | input | 160 | Product terms. Cluster c occupies bits 5c+4 down to 5c |
| clu_en | input | 32 | Per-cluster steering enable |
| clu_off | input | 96 | Per-cluster offset. Cluster c occupies bits 3c+2 down to 3c |
| sum_out | output | 32 | Sharing-array sum for each macrocell |
| byp_out | output | 32 | Bypass sum: the OR of each macrocell's own cluster |
| cfg_bad | output | 1 | An enabled cluster carries the illegal offset 7 |

## Verification
The bench goes after the wrap boundary: a steering rule without the modulo would lose the terms that clusters 0 to 5 send to outputs 26 to 31, or route them to wrong outputs. It walks a single active term through all 35 positions that feed output 31. A window that is off by one would miss the seventh cluster, or would let offset 7 through. It also holds offset-7 and disabled clusters with live terms, where a design that ignores the enable or fails to reject the illegal offset would show stray ones on `sum_out`. Random legal and partly illegal configurations check that `byp_out` never follows the steering settings.

// File: rtl/ptsa_pkg.sv
package ptsa_pkg;
    localparam int PTSA_CLUSTERS  = 32;
    localparam int PTSA_CLU_TERMS = 5;
    localparam int PTSA_WINDOW    = 7;
    localparam int PTSA_OFF_W     = $clog2(PTSA_WINDOW + 1);

    // Index of the cluster at window position k of output i.
    function automatic int wrap_idx(input int i, input int k, input int n);
        return (i + k) % n;
    endfunction
endpackage

// File: rtl/ptsa_cluster_or.sv
module ptsa_cluster_or #(
    parameter int TERMS = 5
) (
    input  logic [TERMS-1:0] terms,
    output logic             any_hi
);
    assign any_hi = |terms;
endmodule

// File: rtl/ptsa_route_dec.sv
module ptsa_route_dec #(
    parameter int WIN   = 7,
    parameter int OFF_W = 3
) (
    input  logic             en,
    input  logic [OFF_W-1:0] off,
    output logic [WIN-1:0]   sel,
    output logic             bad
);
    localparam logic [OFF_W-1:0] LAST_OK = OFF_W'(WIN - 1);

    for (genvar k = 0; k < WIN; k++) begin : g_pos
        assign sel[k] = en && (off == OFF_W'(k));
    end

    assign bad = en && (off > LAST_OK);
endmodule

// File: rtl/ptsa_share_array.sv
module ptsa_share_array
    import ptsa_pkg::*;
#(
    parameter int NUM_CLU   = PTSA_CLUSTERS,
    parameter int CLU_TERMS = PTSA_CLU_TERMS,
    parameter int WIN       = PTSA_WINDOW,
    parameter int OFF_W     = PTSA_OFF_W
) (
    input  logic [NUM_CLU*CLU_TERMS-1:0] pt_in,
    input  logic [NUM_CLU-1:0]           clu_en,
    input  logic [NUM_CLU*OFF_W-1:0]     clu_off,
    output logic [NUM_CLU-1:0]           sum_out,
    output logic [NUM_CLU-1:0]           byp_out,
    output logic                         cfg_bad
);
    logic [NUM_CLU-1:0] clu_or;
    logic [NUM_CLU-1:0] clu_bad;
    logic [WIN-1:0]     clu_sel [NUM_CLU];
    logic [WIN-1:0]     contrib [NUM_CLU];

    for (genvar c = 0; c < NUM_CLU; c++) begin : g_clu
        ptsa_cluster_or #(.TERMS(CLU_TERMS)) u_or (
            .terms  (pt_in[c*CLU_TERMS +: CLU_TERMS]),
            .any_hi (clu_or[c])
        );
        ptsa_route_dec #(.WIN(WIN), .OFF_W(OFF_W)) u_dec (
            .en  (clu_en[c]),
            .off (clu_off[c*OFF_W +: OFF_W]),
            .sel (clu_sel[c]),
            .bad (clu_bad[c])
        );
    end

    // Output i gathers window positions 0..WIN-1, wrapping past the top.
    for (genvar i = 0; i < NUM_CLU; i++) begin : g_out
        for (genvar k = 0; k < WIN; k++) begin : g_win
            localparam int SRC = wrap_idx(i, k, NUM_CLU);
            assign contrib[i][k] = clu_sel[SRC][k] & clu_or[SRC];
        end
        assign sum_out[i] = |contrib[i];
    end

    assign byp_out = clu_or;
    assign cfg_bad = |clu_bad;
endmodule

// File: rtl/ptsa_share_array_chk.sv
module ptsa_share_array_chk #(
    parameter int NUM_CLU   = 32,
    parameter int CLU_TERMS = 5,
    parameter int OFF_W     = 3
) (
    input logic [NUM_CLU*CLU_TERMS-1:0] pt_in,
    input logic [NUM_CLU-1:0]           clu_en,
    input logic [NUM_CLU*OFF_W-1:0]     clu_off,
    input logic [NUM_CLU-1:0]           sum_out,
    input logic [NUM_CLU-1:0]           byp_out,
    input logic                         cfg_bad
);
    always_comb begin
        for (int c = 0; c < NUM_CLU; c++) begin
            AST_BYPASS_OWN: assert (byp_out[c] == (pt_in[c*CLU_TERMS +: CLU_TERMS] != '0)); // R1
        end
        AST_SUM_FEWER_THAN_EN: assert ($countones(sum_out) <= $countones(clu_en)); // R2
        AST_IDLE_SUM_ZERO: assert (clu_en != '0 || sum_out == '0); // R5
        AST_IDLE_NO_BAD: assert (clu_en != '0 || !cfg_bad); // R6
        AST_IDENTITY_EQ_BYP: assert (!(clu_en == '1 && clu_off == '0) || sum_out == byp_out); // R2
    end
endmodule

bind ptsa_share_array ptsa_share_array_chk #(
    .NUM_CLU(NUM_CLU), .CLU_TERMS(CLU_TERMS), .OFF_W(OFF_W)
) u_chk (
    .pt_in(pt_in), .clu_en(clu_en), .clu_off(clu_off),
    .sum_out(sum_out), .byp_out(byp_out), .cfg_bad(cfg_bad)
);

// File: tb/ptsa_share_array_test.sv
module ptsa_share_array_test;
    localparam int CLK_PERIOD = 10;
    localparam int N = 32;

    logic         clk = 0;
    logic [159:0] pt_in = '0;
    logic [31:0]  clu_en = '0;
    logic [95:0]  clu_off = '0;
    logic [31:0]  sum_out, byp_out;
    logic         cfg_bad;
    int errors = 0, checks = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ptsa_share_array uut (
        .pt_in(pt_in), .clu_en(clu_en), .clu_off(clu_off),
        .sum_out(sum_out), .byp_out(byp_out), .cfg_bad(cfg_bad)
    );

    // Reference: per output, scan its seven-wide window with wrap.
    function automatic logic [31:0] ref_sum();
        logic [31:0] r = '0;
        for (int i = 0; i < N; i++)
            for (int k = 0; k < 7; k++) begin
                int c = (i + k) % N;
                if (clu_en[c] && int'(clu_off[3*c +: 3]) == k && pt_in[5*c +: 5] != 0)
                    r[i] = 1'b1;
            end
        return r;
    endfunction

    function automatic logic [31:0] ref_byp();
        logic [31:0] r;
        for (int c = 0; c < N; c++) r[c] = (pt_in[5*c +: 5] != 0);
        return r;
    endfunction

    function automatic logic ref_bad();
        for (int c = 0; c < N; c++)
            if (clu_en[c] && clu_off[3*c +: 3] == 3'd7) return 1'b1;
        return 1'b0;
    endfunction

    task automatic compare(input string req);
        logic [31:0] es = ref_sum(), eb = ref_byp();
        logic ebad = ref_bad();
        @(posedge clk); #1;
        checks += 3;
        if (sum_out !== es) begin errors++; $display("FAIL %s sum_out act=%h exp=%h", req, sum_out, es); end
        if (byp_out !== eb) begin errors++; $display("FAIL R1 byp_out act=%h exp=%h", byp_out, eb); end
        if (cfg_bad !== ebad) begin errors++; $display("FAIL R6 cfg_bad act=%b exp=%b", cfg_bad, ebad); end
        @(negedge clk);
    endtask

    task automatic set_off(input int c, input int k);
        clu_off[3*c +: 3] = 3'(k);
    endtask

    initial begin
        @(negedge clk);
        compare("R8 idle");
        // identity steering
        clu_en = '1; clu_off = '0;
        pt_in = {$urandom, $urandom, $urandom, $urandom, $urandom};
        compare("R2 identity");
        // R3 wrap: clusters 0 and 5 to output 31
        clu_en = '0; clu_off = '0; pt_in = '0;
        clu_en[0] = 1; set_off(0, 1); pt_in[0] = 1;
        compare("R3 wrap c0");
        pt_in = '0; clu_en = '0; clu_en[5] = 1; set_off(5, 6); pt_in[27] = 1;
        compare("R3 wrap c5");
        // R7: all 35 terms of output 31, one at a time
        clu_en = '0; clu_off = '0;
        clu_en[31] = 1; set_off(31, 0);
        for (int c = 0; c < 6; c++) begin clu_en[c] = 1; set_off(c, c + 1); end
        for (int t = 0; t < 35; t++) begin
            int c = (t < 5) ? 31 : (t / 5 - 1);
            pt_in = '0; pt_in[5*c + t % 5] = 1;
            compare("R7 wide");
        end
        // R4: no steered cluster yields zero
        pt_in = '0; compare("R4 none");
        // R5 disabled with live terms
        clu_en = '0; pt_in = '1; compare("R5 disabled");
        // R6 illegal offset, enabled and disabled
        clu_off = '1; compare("R6 off7 disabled");
        clu_en[9] = 1; compare("R6 off7 enabled");
        // random legal configurations
        for (int v = 0; v < 300; v++) begin
            pt_in = {$urandom, $urandom, $urandom, $urandom, $urandom};
            for (int w = 0; w < 5; w++) pt_in &= {$urandom, $urandom, $urandom, $urandom, $urandom};
            clu_en = $urandom;
            for (int c = 0; c < N; c++) set_off(c, $urandom % 7);
            compare("R2 R4 random");
        end
        // random with illegal offsets mixed in
        for (int v = 0; v < 100; v++) begin
            pt_in = {$urandom, $urandom, $urandom, $urandom, $urandom};
            clu_en = $urandom & $urandom;
            clu_off = {$urandom, $urandom, $urandom};
            compare("R6 random");
        end
        done = 1;
    end

    initial begin
        for (int n = 0; n < 100000 && !done; n++) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL R8 watchdog act=hung exp=done");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule